// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Byte and Block Access

This block is a serial slave for a two-wire open-drain bus (SMBus-style signalling). It sits in front of a bank of byte-wide control registers held outside the block and turns bus transactions into one-cycle register write pulses and combinational register reads. The master selects single-register or block access through the top bit of the command byte. In single-register mode the low seven command bits name the register. In block mode transfers always begin at a fixed base index and step upward. Both bus lines arrive as synchronised inputs. The data line leaves as a drive-low enable for an external open-drain pad.

A single-register write is: start, device address with write bit, command, one data byte, stop. A single-register read is: start, address with write bit, command, then a repeated start, the address with read bit, one byte returned by the slave, a not-acknowledge from the master, and stop. A block write puts a byte count after the command, then the data bytes. A block read turns the bus round with a repeated start. The slave first returns a byte count equal to the number of registers from the base index to the end of the bank, and then returns those registers in order until the master declines a byte. Any complete byte can end a block transfer.

The controller is one state machine. ST_IDLE waits for a start. ST_ADDR shifts in the address byte and moves to ST_ADDR_ACK on a match, or to ST_SKIP on a mismatch. A write direction goes ST_ADDR_ACK → ST_CMD → ST_CMD_ACK. From there a block command goes to ST_COUNT → ST_COUNT_ACK → ST_WDATA, and a single-register command goes straight to ST_WDATA. ST_WDATA → ST_WDATA_ACK → ST_WDATA repeats while data is accepted. A rejected byte goes to ST_SKIP. A read direction goes ST_ADDR_ACK → ST_TX → ST_TX_ACK. It returns to ST_TX when the master acknowledges and goes to ST_SKIP when it does not. A start in any state goes to ST_ADDR. A stop in any state goes to ST_IDLE.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 7'h69, which is 8'hD2 for a write and 8'hD3 for a read. Any other address gets no acknowledge, and the slave keeps the data line released until the next stop or start.
- R2: A command byte with bit 7 = 1 selects single-register access, and bits 6:0 give the register index. The first data byte after the command is acknowledged and written to that index. Any further data byte in the same transfer is not acknowledged and is not written.
- R3: After a single-register command and a repeated start with the read address, the slave returns the register at that index, most significant bit first.
- R4: A command byte of 8'h00 selects block access. In a block write, the byte after the command is a count. The data bytes that follow are acknowledged and written to registers 4, 5, 6 and upward, in ascending order.
- R5: A block-write data byte is not acknowledged and not written once the count is used up or the index has passed the last register (NUM_REGS-1).
- R6: In a block read, the first byte returned is NUM_REGS-4 (12 at defaults). Registers 4 and upward follow in ascending order for as long as the master acknowledges. After a not-acknowledge the slave releases the line.
- R7: The slave only ever pulls the data line low, and changes its drive only while the clock line is low. It drives the line during the acknowledge bit of each accepted byte and during the zero bits of each byte it returns.
- R8: A stop in any state releases the data line and returns the slave to idle. A start in any state restarts address reception, and the command already received is kept for a following read.
- R9: A single-register access at an index of NUM_REGS or above gets no acknowledge for its data byte and writes nothing. A read at such an index returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; must oversample the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_idx | output | IDX_W | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_idx | output | IDX_W | Register index to read |
| reg_rd_data | input | 8 | Contents of the register at reg_rd_idx |

## Verification
Each bus line passes through two synchroniser stages and one edge register, so every slave reaction comes about three clock cycles after the bus edge that causes it. The acknowledge drive and each returned bit therefore appear about three cycles after a clock-line fall. The write strobe is raised in that same cycle after the eighth data bit's falling clock edge. The bench master holds each clock phase for eight cycles and samples the data line in the middle of the high phase, so each result is read well after it is due and well before it can change. Write strobes are matched against a queue of expected index and data pairs filled by the driver tasks. The drive-only-while-clock-low rule is watched on every cycle.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } smb_state_e;

    // Bus events seen by the controller, one cycle wide
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } smb_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output smb_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_s;
    logic                   sda_s;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda   = sda_s;
        evt.scl   = scl_s;
    end

endmodule

// File: rtl/smb_ctrl_fsm.sv
module smb_ctrl_fsm
    import smb_slave_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h69,
    parameter int         NUM_REGS   = 16,
    parameter int         BLOCK_BASE = 4,
    parameter int         IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  smb_evt_t         evt,
    output logic             sda_oe,
    output logic             reg_wr_en,
    output logic [IDX_W-1:0] reg_wr_idx,
    output logic [7:0]       reg_wr_data,
    output logic [IDX_W-1:0] reg_rd_idx,
    input  logic [7:0]       reg_rd_data
);

    localparam logic [7:0] NUM_P   = 8'(NUM_REGS);
    localparam logic [7:0] BASE_P  = 8'(BLOCK_BASE);
    localparam logic [7:0] BLK_CNT = 8'(NUM_REGS - BLOCK_BASE);

    smb_state_e state, state_d;

    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [7:0] ptr;
    logic [7:0] rem;
    logic       rw;
    logic       blk;
    logic       need_cnt;
    logic       mack;

    logic       byte_done;
    logic       ptr_ok;
    logic       accept;
    logic [7:0] tx_next;

    assign byte_done = evt.fall && (bit_cnt == 4'd8);
    assign ptr_ok    = (ptr < NUM_P);
    assign accept    = (rem != 8'd0) && ptr_ok;
    assign tx_next   = need_cnt ? BLK_CNT : (ptr_ok ? reg_rd_data : 8'hFF);

    // Next-state logic
    always_comb begin
        state_d = state;
        if (evt.start) begin
            state_d = ST_ADDR;
        end else if (evt.stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: state_d = state;
                ST_ADDR: if (byte_done)
                    state_d = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (evt.fall)
                    state_d = rw ? ST_TX : ST_CMD;
                ST_CMD: if (byte_done)
                    state_d = ST_CMD_ACK;
                ST_CMD_ACK: if (evt.fall)
                    state_d = blk ? ST_COUNT : ST_WDATA;
                ST_COUNT: if (byte_done)
                    state_d = ST_COUNT_ACK;
                ST_COUNT_ACK: if (evt.fall)
                    state_d = ST_WDATA;
                ST_WDATA: if (byte_done)
                    state_d = accept ? ST_WDATA_ACK : ST_SKIP;
                ST_WDATA_ACK: if (evt.fall)
                    state_d = ST_WDATA;
                ST_TX: if (byte_done)
                    state_d = ST_TX_ACK;
                ST_TX_ACK: if (evt.fall)
                    state_d = mack ? ST_TX : ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            rem         <= '0;
            rw          <= 1'b0;
            blk         <= 1'b0;
            need_cnt    <= 1'b0;
            mack        <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_idx  <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (evt.start || evt.stop) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                        if (evt.rise) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                rw <= shreg[0];
                            end else if (state == ST_CMD) begin
                                blk      <= ~shreg[7];
                                need_cnt <= ~shreg[7];
                                ptr      <= shreg[7] ? {1'b0, shreg[6:0]} : BASE_P;
                                rem      <= shreg[7] ? 8'd1 : 8'd0;
                            end else if (state == ST_COUNT) begin
                                rem <= shreg;
                            end else if (accept) begin
                                reg_wr_en   <= 1'b1;
                                reg_wr_idx  <= ptr[IDX_W-1:0];
                                reg_wr_data <= shreg;
                                ptr         <= ptr + 8'd1;
                                rem         <= rem - 8'd1;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_TX_ACK: begin
                        if (evt.rise) mack <= ~evt.sda;
                        if (evt.fall && ((state == ST_ADDR_ACK) ? rw : mack)) begin
                            txreg <= tx_next;
                            if (need_cnt)    need_cnt <= 1'b0;
                            else if (ptr_ok) ptr      <= ptr + 8'd1;
                        end
                    end
                    ST_TX: begin
                        if (evt.rise) bit_cnt <= bit_cnt + 4'd1;
                        if (evt.fall) begin
                            if (bit_cnt == 4'd8) bit_cnt <= '0;
                            else                 txreg   <= {txreg[6:0], 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:   sda_oe = ~txreg[7];
            default: sda_oe = 1'b0;
        endcase
        reg_rd_idx = ptr[IDX_W-1:0];
    end

    // R2: a strobe only follows a completed data byte
    assert_wr_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ($past(state) == ST_WDATA) && $past(evt.fall));

    // R4: each accepted byte gives exactly one strobe
    assert_wr_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R8: stop always frees the data line
    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> !sda_oe);

    // R7: drive changes only while the clock line is low
    assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(evt.start) && !$past(evt.stop)) |-> !evt.scl);

    // R1: a foreign address is never acknowledged
    assert_foreign_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && shreg[7:1] != DEV_ADDR && !evt.start && !evt.stop)
        |=> !sda_oe);

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
    import smb_slave_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 16,
    parameter int         BLOCK_BASE  = 4,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             reg_wr_en,
    output logic [IDX_W-1:0] reg_wr_idx,
    output logic [7:0]       reg_wr_data,
    output logic [IDX_W-1:0] reg_rd_idx,
    input  logic [7:0]       reg_rd_data
);

    smb_evt_t evt;

    smb_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smb_ctrl_fsm #(
        .DEV_ADDR   (DEV_ADDR),
        .NUM_REGS   (NUM_REGS),
        .BLOCK_BASE (BLOCK_BASE),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data),
        .reg_rd_idx  (reg_rd_idx),
        .reg_rd_data (reg_rd_data)
    );

endmodule

// File: tb/smb_regbank_slave_tb.sv
module smb_regbank_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NREG       = 16;
    localparam int IW         = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_bus;
    logic          sda_oe;
    logic          reg_wr_en;
    logic [IW-1:0] reg_wr_idx;
    logic [7:0]    reg_wr_data;
    logic [IW-1:0] reg_rd_idx;
    logic [7:0]    reg_rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    int r7_viol = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smb_regbank_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data),
        .reg_rd_idx  (reg_rd_idx),
        .reg_rd_data (reg_rd_data)
    );

    function automatic logic [7:0] dflt(input int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    // External register file model
    logic [7:0] rf [NREG];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= dflt(i);
        end else if (reg_wr_en) begin
            rf[reg_wr_idx] <= reg_wr_data;
        end
    end
    assign reg_rd_data = rf[reg_rd_idx];

    // Scoreboard
    typedef struct { int idx; int data; } wr_item_t;
    wr_item_t   exp_q[$];
    logic [7:0] shadow [NREG];

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_write(input int idx, input int data);
        wr_item_t it;
        it.idx = idx;
        it.data = data;
        exp_q.push_back(it);
        shadow[idx] = 8'(data);
    endtask

    // Monitor: every strobe must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                check_eq("R5", "unexpected write idx", int'(reg_wr_idx), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check_eq("R4", "write idx", int'(reg_wr_idx), it.idx);
                check_eq("R4", "write data", int'(reg_wr_data), it.data);
            end
        end
    end

    // R7 observer: no drive change while clock line is high
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && (sda_oe !== prev_oe)) r7_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b0; wait_h();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b1; wait_h();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wait_h();
        m_scl = 1'b1; wait_h();
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        b = sda_bus;
        repeat (HALF/2) @(negedge clk);
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = x ? 0 : 1;
    endtask

    task automatic recv_byte(output int b, input bit give_ack);
        logic x;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            v[i] = x;
        end
        put_bit(!give_ack);
        b = int'(v);
    endtask

    task automatic open_cmd(input logic [7:0] cmd, input string req);
        int ack;
        bus_start();
        send_byte(8'hD2, ack); check_eq(req, "addr ack", ack, 1);
        send_byte(cmd, ack);   check_eq(req, "cmd ack", ack, 1);
    endtask

    task automatic byte_read(input int off, input int exp, input string req);
        int ack;
        int v;
        open_cmd(8'(8'h80 | off), req);
        bus_start();
        send_byte(8'hD3, ack); check_eq(req, "read addr ack", ack, 1);
        recv_byte(v, 1'b0);    check_eq(req, "read data", v, exp);
        bus_stop();
    endtask

    initial begin
        int ack;
        int v;
        for (int i = 0; i < NREG; i++) shadow[i] = dflt(i);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R7", "reset sda_oe", int'(sda_oe), 0);
        check_eq("R7", "reset wr_en", int'(reg_wr_en), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: foreign address ignored
        bus_start();
        send_byte(8'hA0, ack); check_eq("R1", "foreign addr ack", ack, 0);
        send_byte(8'h80, ack); check_eq("R1", "silent after mismatch", ack, 0);
        bus_stop();
        check_eq("R1", "idle after stop", int'(sda_oe), 0);

        // R2: single-register write, second byte refused
        open_cmd(8'h86, "R2");
        expect_write(6, 8'h3C);
        send_byte(8'h3C, ack); check_eq("R2", "data ack", ack, 1);
        send_byte(8'h55, ack); check_eq("R2", "extra byte nack", ack, 0);
        bus_stop();

        // R3: single-register reads
        byte_read(6, 8'h3C, "R3");
        byte_read(2, int'(shadow[2]), "R3");

        // R4: block write of three bytes from index 4
        open_cmd(8'h00, "R4");
        send_byte(8'd3, ack); check_eq("R4", "count ack", ack, 1);
        expect_write(4, 8'h11); expect_write(5, 8'h22); expect_write(6, 8'h33);
        send_byte(8'h11, ack); check_eq("R4", "data0 ack", ack, 1);
        send_byte(8'h22, ack); check_eq("R4", "data1 ack", ack, 1);
        send_byte(8'h33, ack); check_eq("R4", "data2 ack", ack, 1);
        bus_stop();
        byte_read(5, 8'h22, "R4");

        // R5: count exhausted
        open_cmd(8'h00, "R5");
        send_byte(8'd2, ack); check_eq("R5", "count ack", ack, 1);
        expect_write(4, 8'h44); expect_write(5, 8'h55);
        send_byte(8'h44, ack); check_eq("R5", "data0 ack", ack, 1);
        send_byte(8'h55, ack); check_eq("R5", "data1 ack", ack, 1);
        send_byte(8'h66, ack); check_eq("R5", "over count nack", ack, 0);
        bus_stop();
        byte_read(6, 8'h33, "R5");

        // R5: end of bank reached
        open_cmd(8'h00, "R5");
        send_byte(8'd20, ack); check_eq("R5", "count ack", ack, 1);
        for (int k = 0; k < 12; k++) begin
            expect_write(4 + k, 8'h70 + k);
            send_byte(8'(8'h70 + k), ack);
            check_eq("R5", "in-bank ack", ack, 1);
        end
        send_byte(8'hEE, ack); check_eq("R5", "past bank nack", ack, 0);
        bus_stop();

        // R6: block read, count then registers
        open_cmd(8'h00, "R6");
        bus_start();
        send_byte(8'hD3, ack); check_eq("R6", "read addr ack", ack, 1);
        recv_byte(v, 1'b1);    check_eq("R6", "byte count", v, 12);
        for (int k = 0; k < 12; k++) begin
            recv_byte(v, k != 11);
            check_eq("R6", "block data", v, int'(shadow[4 + k]));
        end
        bus_stop();
        check_eq("R6", "released after nack", int'(sda_oe), 0);

        // R9: out-of-bank single access
        open_cmd(8'h94, "R9");
        send_byte(8'h5A, ack); check_eq("R9", "oob data nack", ack, 0);
        bus_stop();
        byte_read(20, 8'hFF, "R9");
        byte_read(127, 8'hFF, "R9");

        // R8: stop after command, then a fresh write
        open_cmd(8'h87, "R8");
        bus_stop();
        check_eq("R8", "sda_oe after stop", int'(sda_oe), 0);
        open_cmd(8'h87, "R8");
        expect_write(7, 8'h9A);
        send_byte(8'h9A, ack); check_eq("R8", "data ack", ack, 1);
        bus_stop();
        // R8: start mid-address restarts reception
        bus_start();
        for (int i = 7; i >= 4; i--) put_bit(1'b1);
        bus_start();
        send_byte(8'hD2, ack); check_eq("R8", "restart addr ack", ack, 1);
        send_byte(8'h88, ack); check_eq("R8", "restart cmd ack", ack, 1);
        bus_start();
        send_byte(8'hD3, ack); check_eq("R8", "read addr ack", ack, 1);
        recv_byte(v, 1'b0);    check_eq("R8", "kept command read", v, int'(shadow[8]));
        bus_stop();
        byte_read(7, 8'h9A, "R8");

        repeat (10) @(negedge clk);
        check_eq("R7", "drive changes while clock high", r7_viol, 0);
        check_eq("R5", "pending expected writes", exp_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule